// File: doc/BRIEF.md
# Serial Field Memory Write Port

This block is the write side of a serial field memory: a first-in first-out delay store that a video pipeline fills at its own pixel clock. A write-reset input returns the write address pointer to zero at the start of each field. A write-enable input decides whether a clock edge is an active write cycle, meaning a cycle that captures data and advances the pointer. A separate input-enable works as a write mask. A masked cycle still advances the pointer but leaves the addressed word untouched, so a picture can be overlaid into a region of a stored field.

The block drives a plain synchronous memory write port (address, data, strobe) into an array of parameterised depth. Every write reaches that port one clock later than the matching read would leave a read port. This lets the data output of one store feed the data input of the next directly in a cascade.

The block also checks two usage rules. It raises a sticky flag if the write-reset is raised again too soon after the previous reset. It raises the same flag if a write pass holds fewer than the minimum number of active write cycles.

Top module: `field_wr_port`

## Requirements
- R1: The rising edge of the clock that performs a write-reset cycle sets the write pointer to zero, so the next active write cycle stores at address 0.
- R2: In a write-reset cycle the write-enable and input-enable levels are ignored: no strobe results and the pointer does not advance.
- R3: Only the first clock edge that samples the write-reset input high is a reset cycle. Further edges while the input stays high are ordinary cycles, governed by write-enable and input-enable.
- R4: On an edge with write-enable high and input-enable high (and no reset cycle), the data input is stored at the current pointer and the pointer advances by one.
- R5: On an edge with write-enable low, nothing is stored and the pointer keeps its value.
- R6: On an edge with write-enable high and input-enable low, no strobe is issued (the addressed word keeps its contents), but the pointer still advances by one.
- R7: A write sampled at clock edge k appears on the memory port (strobe high, address, data) after edge k+1, one clock later than a plain registered output.
- R8: The pointer wraps from DEPTH-1 to 0 on an advancing cycle.
- R9: A write sampled on the edge just before a reset cycle still reaches the memory port. The reset cycle drains it and does not discard it.
- R10: If a reset cycle occurs after fewer than LOW_GAP (default 2) clock edges sampled the write-reset input low since it was last high, the violation flag is set. The first reset after system reset is never flagged.
- R11: If a reset cycle ends a write pass that held fewer than MIN_ACTIVE (default 130) active write cycles, the violation flag is set. Cycles with write-enable high count as active; masked cycles count, and reset cycles do not.
- R12: The violation flag is sticky until system reset, and a pass that keeps both rules leaves it low.
- R13: After system reset the strobe is low, the address output is 0, the flag is low and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock |
| rst | input | 1 | Synchronous active-high system reset |
| wr_rst_i | input | 1 | Write-reset (field start) |
| wr_en_i | input | 1 | Write enable: gates capture and pointer advance |
| in_en_i | input | 1 | Input enable: write mask, pointer still advances |
| din_i | input | DW | Write data |
| mem_addr_o | output | $clog2(DEPTH) | Memory write address |
| mem_data_o | output | DW | Memory write data |
| mem_we_o | output | 1 | Memory write strobe |
| viol_o | output | 1 | Sticky usage-rule violation flag |

## Verification
The main function is driven with unbroken write runs, runs broken by write-enable gaps, and runs broken by input-enable masks. Comparing the next stored address after each gap shows a hold (write-enable low) apart from a skip (mask low). A run longer than the depth shows wrap-around. Reset is driven both as a single-cycle pulse and as a level held for several edges, which separates first-edge reset behaviour from level reset behaviour. Rule-checking passes are built so that each rule breaks alone: a long held reset followed by a quick re-raise breaks only the gap rule, and a short pass with a long gap breaks only the active-cycle rule.

// File: rtl/fwp_pkg.sv
package fwp_pkg;
  // Classification of one write-clock edge.
  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,  // write enable low: hold
    CYC_RESET = 2'd1,  // first edge of write-reset
    CYC_STORE = 2'd2,  // store and advance
    CYC_SKIP  = 2'd3   // masked: advance without store
  } cyc_kind_e;
endpackage

// File: rtl/fwp_cycle_decode.sv
module fwp_cycle_decode
  import fwp_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      wr_rst_i,
  input  logic      wr_en_i,
  input  logic      in_en_i,
  output cyc_kind_e kind_o
);
  logic rst_prev_q;

  always_ff @(posedge clk) begin
    if (rst) rst_prev_q <= 1'b0;
    else     rst_prev_q <= wr_rst_i;
  end

  always_comb begin
    if (wr_rst_i && !rst_prev_q) kind_o = CYC_RESET;
    else if (!wr_en_i)           kind_o = CYC_IDLE;
    else if (in_en_i)            kind_o = CYC_STORE;
    else                         kind_o = CYC_SKIP;
  end

  // R3: a level held high resets only once
  p_first_edge_only_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_rst_i && $past(wr_rst_i) && !$past(rst)) |-> (kind_o != CYC_RESET));
endmodule

// File: rtl/fwp_pointer.sv
module fwp_pointer
  import fwp_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  cyc_kind_e     kind_i,
  output logic [AW-1:0] ptr_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] ptr_q;
  logic          adv;

  assign adv   = (kind_i == CYC_STORE) || (kind_i == CYC_SKIP);
  assign ptr_o = ptr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else if (kind_i == CYC_RESET) begin
      ptr_q <= '0;
    end else if (adv) begin
      ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end
  end

  p_reset_zero_r1: assert property (@(posedge clk) disable iff (rst)
    (kind_i == CYC_RESET) |=> (ptr_q == '0));
  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (kind_i == CYC_IDLE) |=> $stable(ptr_q));
  p_advance_r6: assert property (@(posedge clk) disable iff (rst)
    (adv && ptr_q != LAST) |=> (ptr_q == $past(ptr_q) + 1'b1));
  p_wrap_r8: assert property (@(posedge clk) disable iff (rst)
    (adv && ptr_q == LAST) |=> (ptr_q == '0));
endmodule

// File: rtl/fwp_write_stage.sv
module fwp_write_stage
  import fwp_pkg::*;
#(
  parameter int AW  = 10,
  parameter int DW  = 4,
  parameter int LAT = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  cyc_kind_e     kind_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_data_o,
  output logic          mem_we_o
);
  logic          we_q   [LAT];
  logic [AW-1:0] addr_q [LAT];
  logic [DW-1:0] data_q [LAT];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LAT; i++) begin
        we_q[i]   <= 1'b0;
        addr_q[i] <= '0;
        data_q[i] <= '0;
      end
    end else begin
      we_q[0]   <= (kind_i == CYC_STORE);
      addr_q[0] <= addr_i;
      data_q[0] <= data_i;
      for (int i = 1; i < LAT; i++) begin
        we_q[i]   <= we_q[i-1];
        addr_q[i] <= addr_q[i-1];
        data_q[i] <= data_q[i-1];
      end
    end
  end

  assign mem_we_o   = we_q[LAT-1];
  assign mem_addr_o = addr_q[LAT-1];
  assign mem_data_o = data_q[LAT-1];
endmodule

// File: rtl/fwp_rules.sv
module fwp_rules
  import fwp_pkg::*;
#(
  parameter int MIN_ACTIVE = 130,
  parameter int LOW_GAP    = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      wr_rst_i,
  input  cyc_kind_e kind_i,
  output logic      viol_o
);
  localparam int CW = $clog2(MIN_ACTIVE + 1);
  localparam int GW = $clog2(LOW_GAP + 1);
  localparam logic [CW-1:0] ACT_MIN = CW'(MIN_ACTIVE);
  localparam logic [GW-1:0] GAP_MIN = GW'(LOW_GAP);

  logic [CW-1:0] act_q;
  logic [GW-1:0] gap_q;
  logic          armed_q;
  logic          viol_q;
  logic          active;

  assign active = (kind_i == CYC_STORE) || (kind_i == CYC_SKIP);
  assign viol_o = viol_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q   <= '0;
      gap_q   <= GAP_MIN;
      armed_q <= 1'b0;
      viol_q  <= 1'b0;
    end else begin
      if (wr_rst_i)              gap_q <= '0;
      else if (gap_q < GAP_MIN)  gap_q <= gap_q + 1'b1;

      if (kind_i == CYC_RESET) begin
        if (armed_q && ((act_q < ACT_MIN) || (gap_q < GAP_MIN))) viol_q <= 1'b1;
        act_q   <= '0;
        armed_q <= 1'b1;
      end else if (active && act_q < ACT_MIN) begin
        act_q <= act_q + 1'b1;
      end
    end
  end

  p_sticky_r12: assert property (@(posedge clk) disable iff (rst)
    viol_o |=> viol_o);
  p_too_soon_r10: assert property (@(posedge clk) disable iff (rst)
    (kind_i == CYC_RESET && armed_q && gap_q < GAP_MIN) |=> viol_o);
  p_short_pass_r11: assert property (@(posedge clk) disable iff (rst)
    (kind_i == CYC_RESET && armed_q && act_q < ACT_MIN) |=> viol_o);
endmodule

// File: rtl/field_wr_port.sv
module field_wr_port
  import fwp_pkg::*;
#(
  parameter int DEPTH      = 1024,
  parameter int DW         = 4,
  parameter int MIN_ACTIVE = 130,
  parameter int LOW_GAP    = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_rst_i,
  input  logic                     wr_en_i,
  input  logic                     in_en_i,
  input  logic [DW-1:0]            din_i,
  output logic [$clog2(DEPTH)-1:0] mem_addr_o,
  output logic [DW-1:0]            mem_data_o,
  output logic                     mem_we_o,
  output logic                     viol_o
);
  localparam int AW  = $clog2(DEPTH);
  localparam int LAT = 2;  // capture stage plus one cascade-delay stage

  cyc_kind_e     kind;
  logic [AW-1:0] ptr;

  fwp_cycle_decode u_decode (
    .clk(clk), .rst(rst), .wr_rst_i(wr_rst_i), .wr_en_i(wr_en_i),
    .in_en_i(in_en_i), .kind_o(kind)
  );

  fwp_pointer #(.DEPTH(DEPTH), .AW(AW)) u_pointer (
    .clk(clk), .rst(rst), .kind_i(kind), .ptr_o(ptr)
  );

  fwp_write_stage #(.AW(AW), .DW(DW), .LAT(LAT)) u_stage (
    .clk(clk), .rst(rst), .kind_i(kind), .addr_i(ptr), .data_i(din_i),
    .mem_addr_o(mem_addr_o), .mem_data_o(mem_data_o), .mem_we_o(mem_we_o)
  );

  fwp_rules #(.MIN_ACTIVE(MIN_ACTIVE), .LOW_GAP(LOW_GAP)) u_rules (
    .clk(clk), .rst(rst), .wr_rst_i(wr_rst_i), .kind_i(kind), .viol_o(viol_o)
  );

  // R6/R7: a strobe traces back two edges to enable and mask both high
  p_strobe_qual_r6: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |-> ($past(wr_en_i, 2) && $past(in_en_i, 2)));
  // R2: no strobe from a reset cycle
  p_no_store_on_reset_r2: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |-> !($past(wr_rst_i, 2) && !$past(wr_rst_i, 3)));
endmodule

// File: tb/test_field_wr_port.sv
module test_field_wr_port;
  localparam int DEPTH = 20;
  localparam int DW    = 4;
  localparam int MINA  = 8;
  localparam int AW    = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_rst = 1'b0, wr_en = 1'b0, in_en = 1'b0;
  logic [DW-1:0] din = '0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_data;
  logic mem_we, viol;

  always #4 clk = ~clk;  // 125 MHz

  field_wr_port #(.DEPTH(DEPTH), .DW(DW), .MIN_ACTIVE(MINA), .LOW_GAP(2)) i_field_wr_port (
    .clk(clk), .rst(rst), .wr_rst_i(wr_rst), .wr_en_i(wr_en), .in_en_i(in_en),
    .din_i(din), .mem_addr_o(mem_addr), .mem_data_o(mem_data), .mem_we_o(mem_we),
    .viol_o(viol)
  );

  int n_run = 0, n_fail = 0;
  bit done = 0;

  // bench-side expectation state
  int    m_ptr = 0;
  bit    m_prev = 0;
  bit    pend_we = 0;
  int    pend_addr = 0, pend_data = 0;
  string pend_tag = "R13";

  task automatic chk(string tag, string what, int act, int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Drive one cycle (called at a negedge); after the next negedge check the
  // write driven one call earlier, which has now reached the memory port.
  task automatic cyc(bit r, bit we, bit ie, int d, string tag);
    bit nw = 0; int na = 0;
    wr_rst = r; wr_en = we; in_en = ie; din = DW'(d);
    if (r && !m_prev) m_ptr = 0;
    else if (we) begin
      nw = ie; na = m_ptr;
      m_ptr = (m_ptr == DEPTH - 1) ? 0 : m_ptr + 1;
    end
    m_prev = r;
    @(posedge clk); @(negedge clk);
    chk(pend_tag, "strobe", int'(mem_we), int'(pend_we));
    if (pend_we) begin
      chk(pend_tag, "addr", int'(mem_addr), pend_addr);
      chk(pend_tag, "data", int'(mem_data), pend_data);
    end
    pend_we = nw; pend_addr = na; pend_data = d & 15; pend_tag = tag;
  endtask

  task automatic sysrst();
    @(negedge clk);
    rst = 1'b1; wr_rst = 0; wr_en = 0; in_en = 0; din = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_ptr = 0; m_prev = 0; pend_we = 0; pend_tag = "R13";
  endtask

  task automatic t_reset_state();
    sysrst();
    chk("R13", "strobe", int'(mem_we), 0);
    chk("R13", "addr", int'(mem_addr), 0);
    chk("R13", "viol", int'(viol), 0);
    cyc(0, 1, 1, 4'h9, "R13");  // first store lands at 0
    cyc(0, 0, 0, 0, "R13");
  endtask

  task automatic t_reset_basic();
    sysrst();
    for (int i = 0; i < 3; i++) cyc(0, 1, 1, i + 1, "R4");
    cyc(1, 1, 1, 4'hF, "R2");  // enables high, ignored
    for (int i = 0; i < 6; i++) cyc(0, 1, 1, 4'hA ^ i, i < 2 ? "R1" : "R7");
    cyc(0, 0, 0, 0, "R7");
  endtask

  task automatic t_hold();
    sysrst();
    cyc(0, 1, 1, 4'h3, "R5");
    cyc(0, 0, 1, 4'h7, "R5");
    cyc(0, 0, 0, 4'h8, "R5");
    cyc(0, 1, 1, 4'h5, "R5");  // expect address 1
    cyc(0, 0, 0, 0, "R5");
  endtask

  task automatic t_mask();
    sysrst();
    cyc(0, 1, 1, 4'h1, "R6");
    cyc(0, 1, 0, 4'h2, "R6");
    cyc(0, 1, 0, 4'h3, "R6");
    cyc(0, 1, 1, 4'h4, "R6");  // expect address 3
    cyc(0, 0, 0, 0, "R6");
  endtask

  task automatic t_wrap();
    sysrst();
    for (int i = 0; i < DEPTH + 4; i++) cyc(0, 1, 1, i, "R8");
    cyc(0, 0, 0, 0, "R8");
  endtask

  task automatic t_held_reset();
    sysrst();
    cyc(0, 1, 1, 4'h1, "R3");
    cyc(0, 1, 1, 4'h2, "R3");
    cyc(1, 1, 1, 4'h3, "R3");  // reset cycle
    cyc(1, 1, 1, 4'h4, "R3");  // ordinary store at 0
    cyc(1, 1, 1, 4'h5, "R3");  // ordinary store at 1
    cyc(0, 1, 1, 4'h6, "R3");  // store at 2
    cyc(0, 0, 0, 0, "R3");
  endtask

  task automatic t_drain();
    sysrst();
    cyc(0, 1, 1, 4'hC, "R9");
    cyc(0, 1, 1, 4'hD, "R9");  // checked while the reset cycle runs
    cyc(1, 0, 0, 0, "R9");
    cyc(0, 0, 0, 0, "R9");
  endtask

  task automatic t_good_pass();
    sysrst();
    cyc(1, 0, 0, 0, "R12");
    for (int i = 0; i < MINA + 1; i++) cyc(0, 1, i % 2, i, "R12");
    cyc(1, 0, 0, 0, "R12");
    chk("R12", "viol", int'(viol), 0);
    cyc(0, 0, 0, 0, "R12");
  endtask

  task automatic t_too_soon();
    sysrst();
    for (int i = 0; i < MINA + 2; i++) cyc(1, 1, 1, i, "R10");  // held high
    cyc(0, 0, 0, 0, "R10");
    chk("R10", "viol", int'(viol), 0);
    cyc(1, 0, 0, 0, "R10");  // only one low edge since release
    chk("R10", "viol", int'(viol), 1);
    cyc(0, 0, 0, 0, "R10");
  endtask

  task automatic t_short_pass();
    sysrst();
    cyc(1, 0, 0, 0, "R11");
    for (int i = 0; i < 3; i++) cyc(0, 1, 1, i, "R11");
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, 0, "R11");
    chk("R11", "viol", int'(viol), 0);
    cyc(1, 0, 0, 0, "R11");
    chk("R11", "viol", int'(viol), 1);
    // sticky through a clean pass
    for (int i = 0; i < MINA + 2; i++) cyc(0, 1, 1, i, "R12");
    cyc(1, 0, 0, 0, "R12");
    chk("R12", "viol", int'(viol), 1);
    cyc(0, 0, 0, 0, "R12");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_reset_basic();
    t_hold();
    t_mask();
    t_wrap();
    t_held_reset();
    t_drain();
    t_good_pass();
    t_too_soon();
    t_short_pass();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule